// File: doc/BRIEF.md
# SAR Converter Host Sequencer with End-of-Conversion Interrupt

This block drives a 14-bit successive-approximation converter over a three-wire serial link (SPI mode 3: clock idles high, data launched on falling edges, taken on rising edges) plus a separate convert strobe. A host request pulses the strobe high for a fixed number of cycles and then holds it low. The converter's data line floats during conversion and reads high through a pull-up. The sequencer watches that line and treats a low level as the end-of-conversion interrupt. No fixed conversion delay is counted.

Once the line drops, the block runs a burst of serial clocks. The next configuration word is sent out MSB first. A new bit is launched on each falling edge, so the converter takes all 14 bits on the first 14 rising edges. The same clocks bring back the result, MSB first. The converter moves a bit on each falling edge, and the host samples it on the falling edge that follows. When the request asks for configuration readback, 14 more bits follow the result LSB. One final falling edge, the 15th or the 29th, samples the last bit and makes the converter release the line. The result, and the readback word when asked for, appear with a one-cycle valid pulse. If the line never drops within a bounded count after the strobe falls, a timeout pulse ends the sequence instead.

Top module: `sar_host_ctrl`

## Requirements
- R1: After reset the strobe is low, the serial clock is high, ready is high, and valid and timeout are low.
- R2: A start request is taken only while ready is high. A start asserted during a running sequence produces no second strobe and does not alter the configuration being written.
- R3: The strobe stays high for exactly CNV_HIGH clock cycles per accepted request. It is low whenever the serial clock is low.
- R4: The serial clock rests high whenever the block is idle.
- R5: No serial clock edge occurs until the data line has been seen low after the strobe falls.
- R6: The configuration word goes out MSB first on the data-in pin, one bit per falling edge. The pin is stable at every rising edge, so the converter receives the full 14-bit word on rising edges 1 to 14.
- R7: The result is formed MSB first from data-line samples taken on falling edges 2 to 15. Bit 13 of result_o is the first bit sampled.
- R8: When rdback_i was high at the accepted start, falling edges 16 to 29 sample the converter's configuration word MSB first into cfg_rb_o.
- R9: Each sequence issues exactly 15 falling edges without readback and 29 with it. The last of these releases the data line.
- R10: valid_o is a one-cycle pulse per completed sequence.
- R11: If the line stays high for TMO_MAX cycles after the strobe falls, timeout_o pulses for one cycle, no serial clock edge is issued, and the block returns to idle.
- R12: valid_o and timeout_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion (taken when ready) |
| cfg_i | input | 14 | Configuration word to write during the transfer |
| rdback_i | input | 1 | Request configuration readback after the result |
| ready_o | output | 1 | Idle, able to take a request |
| result_o | output | 14 | Last conversion result |
| cfg_rb_o | output | 14 | Last configuration word read back |
| valid_o | output | 1 | One-cycle pulse when results update |
| timeout_o | output | 1 | One-cycle pulse when no end-of-conversion was seen |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock, idles high |
| sdi_o | output | 1 | Serial data to the converter's configuration input |
| sdo_i | input | 1 | Serial data from the converter (pulled up when released) |

## Verification
The assertions check the signal relations that hold on every cycle. These are the strobe width, the strobe being low while the clock is low, the idle-high clock, data-in being stable at rising edges, single-cycle valid, and the timeout returning to idle with no clock activity. Only the bench scenarios can show the actual bit order of the written and returned words, the 15 or 29 falling-edge count, and the pairing of a readback with the configuration written by the previous sequence. They run against a behavioural converter model. The bench also checks that a start during a busy sequence is dropped, and that the block recovers after a timeout.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CNV   = 2'd1,
      ST_WAIT  = 2'd2,
      ST_SHIFT = 2'd3
   } sar_state_t;
endpackage

// File: rtl/sar_tick_div.sv
// Emits a one-cycle tick every DIV cycles while run is high.
module sar_tick_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [CW-1:0] TOP = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sar_busy_timer.sv
// Counts while armed; flags expiry after LIMIT armed cycles.
module sar_busy_timer #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign expired = arm && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!arm)     cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sar_rx_shift.sv
// MSB-first capture register.
module sar_rx_shift #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (shift_en) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl #(
   parameter int DATA_W     = 14,
   parameter int CFG_W      = 14,
   parameter int SCK_DIV    = 2,
   parameter int CNV_HIGH   = 3,
   parameter int TMO_MAX    = 200,
   parameter bit RB_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic              rdback_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] result_o,
   output logic [CFG_W-1:0]  cfg_rb_o,
   output logic              valid_o,
   output logic              timeout_o,
   output logic              cnv_o,
   output logic              sck_o,
   output logic              sdi_o,
   input  logic              sdo_i
);
   import sar_host_pkg::*;

   localparam int RX_W     = RB_SUPPORT ? DATA_W + CFG_W : DATA_W;
   localparam int MAX_FALL = DATA_W + CFG_W + 1;
   localparam int FCW      = $clog2(MAX_FALL + 1);
   localparam int HCW      = $clog2(CNV_HIGH + 1);
   localparam logic [FCW-1:0] LAST_RB  = FCW'(DATA_W + CFG_W + 1);
   localparam logic [FCW-1:0] LAST_NRB = FCW'(DATA_W + 1);
   localparam logic [HCW-1:0] HI_TOP   = HCW'(CNV_HIGH - 1);

   initial begin
      assert (DATA_W >= 2 && CFG_W >= 2) else $error("word widths too small");
      assert (SCK_DIV >= 1)              else $error("SCK_DIV must be >= 1");
      assert (CNV_HIGH >= 1)             else $error("CNV_HIGH must be >= 1");
      assert (TMO_MAX >= 2)              else $error("TMO_MAX must be >= 2");
   end

   sar_state_t        st;
   logic [HCW-1:0]    hi_cnt;
   logic [FCW-1:0]    fall_cnt;
   logic [CFG_W-1:0]  cfg_sr;
   logic              rb_q;
   logic              tick, expired, cap_en, rx_clr;
   logic [RX_W-1:0]   rx_q;
   logic [DATA_W-1:0] res_next;
   logic [CFG_W-1:0]  cfg_next;
   logic [FCW-1:0]    last_fall;

   assign ready_o   = (st == ST_IDLE);
   assign last_fall = rb_q ? LAST_RB : LAST_NRB;
   assign cap_en    = (st == ST_SHIFT) && tick && sck_o && (fall_cnt != '0);
   assign rx_clr    = (st == ST_IDLE) && start_i;

   sar_tick_div #(.DIV(SCK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(st == ST_SHIFT), .tick(tick));

   sar_busy_timer #(.LIMIT(TMO_MAX)) u_tmr (
      .clk(clk), .rst_n(rst_n), .arm(st == ST_WAIT), .expired(expired));

   sar_rx_shift #(.W(RX_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift_en(cap_en),
      .din(sdo_i), .q(rx_q));

   generate
      if (RB_SUPPORT) begin : g_rb
         assign res_next = rb_q ? rx_q[RX_W-1 -: DATA_W] : rx_q[DATA_W-1:0];
         assign cfg_next = rx_q[CFG_W-1:0];
      end else begin : g_norb
         assign res_next = rx_q;
         assign cfg_next = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         hi_cnt    <= '0;
         fall_cnt  <= '0;
         cfg_sr    <= '0;
         rb_q      <= 1'b0;
         cnv_o     <= 1'b0;
         sck_o     <= 1'b1;
         sdi_o     <= 1'b0;
         valid_o   <= 1'b0;
         timeout_o <= 1'b0;
         result_o  <= '0;
         cfg_rb_o  <= '0;
      end else begin
         valid_o   <= 1'b0;
         timeout_o <= 1'b0;
         unique case (st)
            ST_IDLE: if (start_i) begin
               cfg_sr <= cfg_i;
               rb_q   <= rdback_i & RB_SUPPORT;
               cnv_o  <= 1'b1;
               hi_cnt <= '0;
               st     <= ST_CNV;
            end
            ST_CNV: begin
               hi_cnt <= hi_cnt + 1'b1;
               if (hi_cnt == HI_TOP) begin
                  cnv_o <= 1'b0;
                  st    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (!sdo_i) begin
                  fall_cnt <= '0;
                  st       <= ST_SHIFT;
               end else if (expired) begin
                  timeout_o <= 1'b1;
                  st        <= ST_IDLE;
               end
            end
            ST_SHIFT: if (tick) begin
               if (sck_o) begin
                  sck_o    <= 1'b0;
                  fall_cnt <= fall_cnt + 1'b1;
                  sdi_o    <= cfg_sr[CFG_W-1];
                  cfg_sr   <= {cfg_sr[CFG_W-2:0], 1'b0};
               end else begin
                  sck_o <= 1'b1;
                  if (fall_cnt == last_fall) begin
                     sdi_o    <= 1'b0;
                     result_o <= res_next;
                     if (rb_q) cfg_rb_o <= cfg_next;
                     valid_o  <= 1'b1;
                     st       <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_host_ctrl_chk.sv
module sar_host_ctrl_chk #(
   parameter int CNV_HIGH = 3
) (
   input logic clk,
   input logic rst_n,
   input logic cnv_o,
   input logic sck_o,
   input logic sdi_o,
   input logic ready_o,
   input logic valid_o,
   input logic timeout_o
);
   localparam logic [15:0] HI_LIM = 16'(CNV_HIGH);

   logic [15:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_run <= '0;
      else if (cnv_o)  hi_run <= hi_run + 16'd1;
      else             hi_run <= '0;
   end

   // R2
   cnv_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> $past(ready_o));
   // R3
   cnv_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_o |-> (hi_run < HI_LIM));
   // R3
   cnv_full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_o) |-> (hi_run == HI_LIM));
   // R3
   cnv_quiet_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_o |-> !cnv_o);
   // R4
   sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> sck_o);
   // R6
   sdi_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> $stable(sdi_o));
   // R10
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R11
   timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (ready_o && sck_o));
   // R12
   valid_tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && timeout_o));
endmodule

bind sar_host_ctrl sar_host_ctrl_chk #(.CNV_HIGH(CNV_HIGH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o),
   .ready_o(ready_o), .valid_o(valid_o), .timeout_o(timeout_o));

// File: tb/sar_host_ctrl_tb.sv
module sar_host_ctrl_tb;
   localparam int CONV_CYC = 30;
   localparam int TMO      = 200;

   logic clk = 1'b0;
   logic rst_n, start_i, rdback_i;
   logic [13:0] cfg_i;
   logic ready_o, valid_o, timeout_o, cnv_o, sck_o, sdi_o;
   logic [13:0] result_o, cfg_rb_o;
   logic sdo_m;

   int checks = 0, fails = 0, cyc = 0;

   always #5 clk = ~clk;

   sar_host_ctrl #(.SCK_DIV(2), .CNV_HIGH(3), .TMO_MAX(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
      .rdback_i(rdback_i), .ready_o(ready_o), .result_o(result_o),
      .cfg_rb_o(cfg_rb_o), .valid_o(valid_o), .timeout_o(timeout_o),
      .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_m));

   // Behavioural converter model
   logic [13:0] res_m, cfg_cur, cfg_snap, cfg_in;
   logic rb_m, conv_ok, cnv_q, sck_q;
   int conv_cnt, fall_k, rise_k, cnv_rises;

   initial begin
      sdo_m = 1'b1; cfg_cur = 14'h3FFF; cfg_snap = 14'h3FFF; cfg_in = '0;
      res_m = '0; rb_m = 1'b0; conv_ok = 1'b1; cnv_q = 1'b0; sck_q = 1'b1;
      conv_cnt = 0; fall_k = 0; rise_k = 0; cnv_rises = 0;
   end

   always @(posedge clk) begin
      cnv_q <= cnv_o;
      sck_q <= sck_o;
      if (cnv_o && !cnv_q) begin
         sdo_m <= 1'b1; conv_cnt <= CONV_CYC; fall_k <= 0; rise_k <= 0;
         cfg_snap <= cfg_cur; cnv_rises <= cnv_rises + 1;
      end else if (conv_cnt > 0) begin
         conv_cnt <= conv_cnt - 1;
         if (conv_cnt == 1 && conv_ok) sdo_m <= 1'b0;
      end
      if (sck_q && !sck_o) begin
         if (fall_k + 1 <= 14)               sdo_m <= res_m[13 - fall_k];
         else if (rb_m && fall_k + 1 <= 28)  sdo_m <= cfg_snap[27 - fall_k];
         else                                sdo_m <= 1'b1;
         fall_k <= fall_k + 1;
      end
      if (!sck_q && sck_o) begin
         if (rise_k + 1 <= 14) cfg_in <= {cfg_in[12:0], sdi_o};
         if (rise_k + 1 == 14) cfg_cur <= {cfg_in[12:0], sdi_o};
         rise_k <= rise_k + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one request; returns after the valid pulse or a bound
   task automatic run_txn(input logic [13:0] cfg, input logic [13:0] res,
                          input bit rb, output bit got, output bit pulse_ok);
      @(negedge clk);
      res_m = res; rb_m = rb;
      cfg_i = cfg; rdback_i = rb; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got = 1'b0;
      for (int i = 0; i < 2000 && !got; i++) begin
         @(negedge clk);
         if (valid_o) got = 1'b1;
      end
      @(negedge clk);
      pulse_ok = !valid_o;
   endtask

   // {cfg, result, readback}
   localparam logic [28:0] VEC [0:4] = '{
      {14'h2A55, 14'h1234, 1'b0},
      {14'h0F0F, 14'h3FFF, 1'b1},
      {14'h3C00, 14'h0000, 1'b1},
      {14'h0001, 14'h2AAA, 1'b0},
      {14'h1FFE, 14'h1555, 1'b1}
   };

   initial begin
      bit got, pok;
      logic [13:0] prev_cfg;
      int r0;
      rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; rdback_i = 1'b0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(cnv_o == 1'b0, "R1 cnv", cnv_o, 0);
      chk(sck_o == 1'b1, "R1 sck", sck_o, 1);
      chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
      chk(valid_o == 1'b0 && timeout_o == 1'b0, "R1 flags", {valid_o, timeout_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R4 idle clock after reset
      chk(sck_o == 1'b1, "R4 sck idle", sck_o, 1);

      prev_cfg = 14'h3FFF;
      for (int v = 0; v < 5; v++) begin
         run_txn(VEC[v][28:15], VEC[v][14:1], VEC[v][0], got, pok);
         chk(got, "R10 valid seen", got, 1);
         chk(pok, "R10 one-cycle valid", pok, 1);
         // R7 result bit order
         chk(result_o == VEC[v][14:1], "R7 result", result_o, VEC[v][14:1]);
         // R9 falling-edge count
         chk(fall_k == (VEC[v][0] ? 29 : 15), "R9 falls", fall_k, VEC[v][0] ? 29 : 15);
         // R6 configuration delivered
         chk(cfg_cur == VEC[v][28:15], "R6 cfg written", cfg_cur, VEC[v][28:15]);
         // R8 readback of the config in force during this conversion
         if (VEC[v][0])
            chk(cfg_rb_o == prev_cfg, "R8 readback", cfg_rb_o, prev_cfg);
         chk(sck_o == 1'b1 && ready_o, "R4 idle after", sck_o, 1);
         prev_cfg = VEC[v][28:15];
      end

      // R2 start during a busy sequence is dropped
      r0 = cnv_rises;
      @(negedge clk);
      res_m = 14'h0ABC; rb_m = 1'b0;
      cfg_i = 14'h1111; rdback_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      cfg_i = 14'h2222; start_i = 1'b1;
      got = 1'b0;
      for (int i = 0; i < 2000 && !got; i++) begin
         @(negedge clk);
         if (valid_o) got = 1'b1;
      end
      start_i = 1'b0;
      @(negedge clk);
      chk(cnv_rises - r0 == 1, "R2 single strobe", cnv_rises - r0, 1);
      chk(cfg_cur == 14'h1111, "R2 cfg unchanged", cfg_cur, 14'h1111);
      chk(result_o == 14'h0ABC, "R7 result busy case", result_o, 14'h0ABC);
      prev_cfg = 14'h1111;

      // R5 / R11 no end-of-conversion: timeout, no clock edges
      conv_ok = 1'b0;
      @(negedge clk);
      cfg_i = 14'h0333; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got = 1'b0;
      for (int i = 0; i < 1000 && !got; i++) begin
         @(negedge clk);
         if (timeout_o) got = 1'b1;
         if (valid_o) chk(1'b0, "R12 valid during timeout", 1, 0);
      end
      chk(got, "R11 timeout pulse", got, 1);
      chk(fall_k == 0, "R5 no sck before busy", fall_k, 0);
      chk(ready_o == 1'b1, "R11 back to idle", ready_o, 1);
      @(negedge clk);
      chk(timeout_o == 1'b0, "R11 single pulse", timeout_o, 0);
      chk(cfg_cur == 14'h1111, "R11 cfg untouched", cfg_cur, 14'h1111);

      // Recovery after timeout
      conv_ok = 1'b1;
      run_txn(14'h2468, 14'h3579, 1'b1, got, pok);
      chk(got && result_o == 14'h3579, "R7 after timeout", result_o, 14'h3579);
      chk(cfg_rb_o == prev_cfg, "R8 readback after timeout", cfg_rb_o, prev_cfg);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule